// File: doc/BRIEF.md
# Device Identifier Readout Checker

This block belongs to programming equipment. It reads the two identifier words that a memory device presents in its identify mode, then judges them before the equipment picks a programming algorithm. After a start request it raises an identify-mode control. That control stands for the raised voltage the equipment applies to one address pin. The block drives every address line low except the lowest.

The block reads the manufacturer word with the lowest address bit low and the device word with that bit high. Before each read it waits a parameterised number of cycles so the device output can settle. It checks each word for odd parity, where the most significant bit is the parity bit. It compares the words against the expected codes given as parameters. It then leaves identify mode, returns the address lines low and raises done. The captured words and both verdicts stay on the outputs until the next start.

Top module: `idr_checker`

## Requirements
- R1: In synchronous reset, and in the first cycle after it, `id_mode`, `mem_addr`, `mfr_code`, `dev_code`, `parity_err`, `match` and `done` are all zero.
- R2: On the clock edge that samples `start` while idle or done, `id_mode` goes high and `mem_addr` is zero. Bits 1 and up of `mem_addr` are zero at all times. Bit 0 can be high only while `id_mode` is high.
- R3: `mem_data` is sampled as the manufacturer word after `mem_addr[0]` has been low for SETTLE cycles. `mem_addr[0]` then goes high, and `mem_data` is sampled as the device word SETTLE cycles later. The two words appear on `mfr_code` and `dev_code`.
- R4: `done` rises 2*SETTLE+1 clock edges after the edge that samples `start`. While `done` is high, `id_mode` is low and `mem_addr` is zero. `done` holds until the next `start`.
- R5: `parity_err` is high with `done` when either captured word holds an even number of ones across its 16 bits. Bit 15 is the parity bit.
- R6: `match` is high with `done` only when `mfr_code` equals EXP_MFR, `dev_code` equals EXP_DEV and `parity_err` is low.
- R7: `start` has no effect while a readout is in progress. The sequence timing and the captured words are unchanged.
- R8: A `start` while done clears `done` and the verdicts and begins a new readout. A reset during a readout drops `id_mode` and clears every output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a readout, sampled while idle or done |
| mem_data | input | 16 | Data outputs of the device under identification |
| id_mode | output | 1 | Identify-mode control (models the raised address pin level) |
| mem_addr | output | ADDR_W | Address lines to the device; only bit 0 toggles |
| mfr_code | output | 16 | Captured manufacturer word |
| dev_code | output | 16 | Captured device word |
| parity_err | output | 1 | Either word failed odd parity |
| match | output | 1 | Both words as expected and parity clean |
| done | output | 1 | Readout finished, verdicts valid |

## Verification
The hardest case to reach from the ports is an early sample. In that case the block reads a word before the device output has followed the address change. The bench models the device with a two-cycle lag between the address and the data. Any capture made less than SETTLE cycles after an address change therefore picks up the old word. A `start` pulse in the middle of a readout, and a reset partway through, cover the busy cases.

// File: rtl/idr_pkg.sv
package idr_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_LEAVE,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] mfr;
        logic [WORD_W-1:0] dev;
    } id_pair_t;

    function automatic logic odd_ok(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction
endpackage

// File: rtl/idr_sequencer.sv
module idr_sequencer
    import idr_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic id_mode,
    output logic sel_hi,
    output logic take0,
    output logic take1,
    output logic clear,
    output logic done
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    seq_state_t     state;
    logic [CNT_W-1:0] cnt;
    logic           at_last;
    logic           accept;

    assign at_last = (cnt == LAST);
    assign accept  = start && (state == ST_IDLE || state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        state <= ST_RD0;
                        cnt   <= '0;
                    end
                end
                ST_RD0: begin
                    if (at_last) begin
                        state <= ST_RD1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD1: begin
                    if (at_last) begin
                        state <= ST_LEAVE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LEAVE: state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign id_mode = (state == ST_RD0) || (state == ST_RD1);
    assign sel_hi  = (state == ST_RD1);
    assign take0   = (state == ST_RD0) && at_last;
    assign take1   = (state == ST_RD1) && at_last;
    assign clear   = accept;
    assign done    = (state == ST_FIN);

    // R2: the select line is only high inside identify mode
    a_r2_sel_in_mode: assert property (@(posedge clk) disable iff (rst)
        sel_hi |-> id_mode);
    // R4: done holds until a new start arrives
    a_r4_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    // R3: each capture takes place with identify mode active
    a_r3_take_in_mode: assert property (@(posedge clk) disable iff (rst)
        (take0 || take1) |-> id_mode);
endmodule

// File: rtl/idr_capture.sv
module idr_capture
    import idr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take0,
    input  logic              take1,
    input  logic [WORD_W-1:0] data,
    output id_pair_t          words
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            words <= '0;
        end else begin
            if (take0) words.mfr <= data;
            if (take1) words.dev <= data;
        end
    end

    // R3: the manufacturer word is not taken again while the device word is captured
    a_r3_words_ordered: assert property (@(posedge clk) disable iff (rst)
        !(take0 && take1));
endmodule

// File: rtl/idr_judge.sv
module idr_judge
    import idr_pkg::*;
#(
    parameter logic [WORD_W-1:0] EXP_MFR = 16'h0013,
    parameter logic [WORD_W-1:0] EXP_DEV = 16'h8116
) (
    input  logic     done,
    input  id_pair_t words,
    output logic     parity_err,
    output logic     match
);
    logic parity_ok;
    logic codes_eq;

    assign parity_ok  = odd_ok(words.mfr) && odd_ok(words.dev);
    assign codes_eq   = (words.mfr == EXP_MFR) && (words.dev == EXP_DEV);
    assign parity_err = done && !parity_ok;
    assign match      = done && parity_ok && codes_eq;

    // R6: a match never coexists with a parity error
    always_comb begin
        a_r6_match_clean: assert (!(match && parity_err));
    end
endmodule

// File: rtl/idr_checker.sv
module idr_checker
    import idr_pkg::*;
#(
    parameter int                ADDR_W  = 18,
    parameter int                SETTLE  = 3,
    parameter logic [WORD_W-1:0] EXP_MFR = 16'h0013,
    parameter logic [WORD_W-1:0] EXP_DEV = 16'h8116
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] mem_data,
    output logic              id_mode,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mfr_code,
    output logic [WORD_W-1:0] dev_code,
    output logic              parity_err,
    output logic              match,
    output logic              done
);
    logic     sel_hi;
    logic     take0;
    logic     take1;
    logic     clear;
    id_pair_t words;

    idr_sequencer #(.SETTLE(SETTLE)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .id_mode (id_mode),
        .sel_hi  (sel_hi),
        .take0   (take0),
        .take1   (take1),
        .clear   (clear),
        .done    (done)
    );

    idr_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .take0 (take0),
        .take1 (take1),
        .data  (mem_data),
        .words (words)
    );

    idr_judge #(.EXP_MFR(EXP_MFR), .EXP_DEV(EXP_DEV)) u_judge (
        .done       (done),
        .words      (words),
        .parity_err (parity_err),
        .match      (match)
    );

    assign mem_addr = {{(ADDR_W-1){1'b0}}, sel_hi};
    assign mfr_code = words.mfr;
    assign dev_code = words.dev;

    // R2: upper address lines stay low at all times
    a_r2_upper_low: assert property (@(posedge clk) disable iff (rst)
        mem_addr[ADDR_W-1:1] == '0);
    // R4: done is only shown once identify mode is left and the bus is low
    a_r4_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!id_mode && mem_addr == '0));
    // R2: entering identify mode starts with the select line low
    a_r2_enter_low: assert property (@(posedge clk) disable iff (rst)
        $rose(id_mode) |-> !mem_addr[0]);
endmodule

// File: tb/idr_checker_test.sv
module idr_checker_test;
    localparam int ADDR_W = 18;
    localparam int SETTLE = 3;
    localparam logic [15:0] EXP_MFR = 16'h0013;
    localparam logic [15:0] EXP_DEV = 16'h8116;
    localparam int LAT = 2 * SETTLE + 2;   // negedges from start drive to done seen

    // {mfr, dev, expected parity_err, expected match}
    localparam logic [33:0] VEC [7] = '{
        {16'h0013, 16'h8116, 1'b0, 1'b1},
        {16'h0013, 16'h8117, 1'b1, 1'b0},
        {16'h0012, 16'h8116, 1'b1, 1'b0},
        {16'h0007, 16'h8116, 1'b0, 1'b0},
        {16'h0013, 16'h0001, 1'b0, 1'b0},
        {16'h0012, 16'h8117, 1'b1, 1'b0},
        {16'hFFFE, 16'h7FFF, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [15:0] mem_data;
    logic id_mode;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mfr_code, dev_code;
    logic parity_err, match, done;

    int checks = 0;
    int bad = 0;

    logic [15:0] dev_mfr = 16'h0, dev_dev = 16'h0;
    logic m1, m2, a1, a2;

    always #2 clk = ~clk;

    // device model: data follows address and mode with a two-cycle lag
    always_ff @(posedge clk) begin
        m1 <= id_mode; a1 <= mem_addr[0];
        m2 <= m1;      a2 <= a1;
    end
    assign mem_data = m2 ? (a2 ? dev_dev : dev_mfr) : 16'h0000;

    idr_checker #(.ADDR_W(ADDR_W), .SETTLE(SETTLE), .EXP_MFR(EXP_MFR), .EXP_DEV(EXP_DEV)) uut (
        .clk(clk), .rst(rst), .start(start), .mem_data(mem_data),
        .id_mode(id_mode), .mem_addr(mem_addr), .mfr_code(mfr_code),
        .dev_code(dev_code), .parity_err(parity_err), .match(match), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic readout(input logic [15:0] m, input logic [15:0] d,
                           input logic pulse_mid, output int lat);
        dev_mfr = m; dev_dev = d;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 1;
        check("R2 mode entered", {31'b0, id_mode}, 32'd1);
        check("R2 addr low on entry", 32'(mem_addr), 32'd0);
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (pulse_mid && lat == 3) start = 1'b1;
            if (pulse_mid && lat == 4) start = 1'b0;
            if (lat == SETTLE + 1) begin
                check("R3 select high for word 1", 32'(mem_addr), 32'd1);
                check("R3 mode held", {31'b0, id_mode}, 32'd1);
            end
        end
    endtask

    initial begin : watchdog
        #400000;
        bad++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 id_mode", {31'b0, id_mode}, 32'd0);
        check("R1 addr", 32'(mem_addr), 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 codes", {mfr_code, dev_code}, 32'd0);
        check("R1 verdicts", {30'b0, parity_err, match}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", {29'b0, id_mode, done, match}, 32'd0);

        for (int i = 0; i < 7; i++) begin
            readout(VEC[i][33:18], VEC[i][17:2], 1'b0, lat);
            check("R4 latency", 32'(lat), 32'(LAT));
            check("R4 bus quiet at done", {31'b0, id_mode}, 32'd0);
            check("R4 addr zero at done", 32'(mem_addr), 32'd0);
            check("R3 captured words", {mfr_code, dev_code}, VEC[i][33:2]);
            check("R5 parity_err", {31'b0, parity_err}, {31'b0, VEC[i][1]});
            check("R6 match", {31'b0, match}, {31'b0, VEC[i][0]});
            repeat (2) @(negedge clk);
            check("R4 done held", {31'b0, done}, 32'd1);
        end

        // R7: start pulsed mid-readout is ignored
        readout(EXP_MFR, EXP_DEV, 1'b1, lat);
        check("R7 latency unchanged", 32'(lat), 32'(LAT));
        check("R7 words unchanged", {mfr_code, dev_code}, {EXP_MFR, EXP_DEV});
        check("R7 match", {31'b0, match}, 32'd1);

        // R8: start from done clears verdicts in the next cycle
        dev_mfr = 16'h0012;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R8 done cleared", {29'b0, done, match, parity_err}, 32'd0);
        check("R8 words cleared", {mfr_code, dev_code}, 32'd0);
        // R8: reset during readout
        repeat (SETTLE + 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset drops mode", {31'b0, id_mode}, 32'd0);
        check("R8 reset clears outputs", {mfr_code, dev_code}, 32'd0);
        check("R8 reset addr", 32'(mem_addr), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 stays idle", {30'b0, id_mode, done}, 32'd0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule